// File: doc/BRIEF.md
# Lockable Pad Multiplexer

This block connects a small set of shared I/O pads to on-chip peripherals through software-programmed selects. Each peripheral input picks its source from a pad or from a fixed level. Each pad picks what it drives from a peripheral output or a fixed level, or it can float. Every route is combinational and is chosen by a select register. Those registers are written through a simple 32-bit word port.

A single lock bit guards every select register. It comes out of reset set, which leaves the selects writable. Software clears it by writing a one, and nothing except a reset can set it again. After that the pad routing is frozen. All pads float out of reset, so no pad is driven until software asks for it.

The register port takes byte offsets, and the two low address bits are not decoded. The lock word sits at offset 0x00. The eight peripheral-input selects follow at 0x04 to 0x20, one per word. The four pad-output selects follow at 0x24 to 0x30, one per word.

Top module: `pad_route_mux`

## Requirements
- R1: After reset the lock word reads 1, every input select reads 0 and every output select reads 2. Every pad therefore has output enable 0 and output data 0, and every peripheral input is 0.
- R2: An input select holds bits [2:0] of the written word, and an output select holds bits [3:0]. All other bits of a select word, and bits [31:1] of the lock word, read as 0.
- R3: Reads of offsets from 0x34 through 0xFC return 0. Writes to those offsets change no register.
- R4: Input select code 0 drives its peripheral input to 0, and code 1 drives it to 1, whatever the pads carry.
- R5: Input select code n with 2 ≤ n ≤ 5 drives its peripheral input from pad n−2.
- R6: Input select codes 6 and 7, which point past the last pad, drive the peripheral input to 0.
- R7: Output select code 0 drives the pad with enable 1 and data 0, and code 1 drives it with enable 1 and data 1.
- R8: Output select code 2 puts the pad in high impedance, with enable 0 and data 0. Data is 0 whenever enable is 0.
- R9: Output select code n with 3 ≤ n ≤ 10 drives the pad with enable 1 and data from peripheral output n−3.
- R10: Output select codes 11 to 15 leave the pad with enable 0 and data 0.
- R11: Writing a word with bit 0 set to the lock offset clears the lock. Writing bit 0 as 0 has no effect. Once cleared, the lock stays 0 until reset.
- R12: While the lock is 0, writes to select registers are ignored. Readback and routing keep their earlier values.
- R13: A register write takes effect at the rising clock edge on which the write strobe is sampled high. A read during that cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| periph_to_core | output | 8 | Peripheral input values |
| periph_from_core | input | 8 | Peripheral output values |
| pad_in | input | 4 | Values seen at the pads |
| pad_out | output | 4 | Data driven toward the pads |
| pad_oe | output | 4 | Pad output enables |

## Verification
The hardest state to reach from the ports is a cleared lock with an active, non-default routing behind it. A frozen register looks just like one that was never written unless its stored value differs from what the blocked write carries.

The bench first programs distinct routes, then clears the lock, then tries to overwrite each route with a value whose effect is visible at the pads and peripheral inputs. It finally reapplies reset to show that only reset restores write access. The select codes are swept exhaustively against every pad pattern and a set of peripheral-output patterns, so the out-of-range codes are covered alongside the valid ones.

// File: rtl/pad_route_pkg.sv
// Package: pad_route_pkg
// Shared select-code constants for the pad multiplexer.
// Assumes the low codes are reserved for fixed levels as listed below.
package pad_route_pkg;
    localparam int unsigned REG_W         = 32;
    // peripheral-input select codes
    localparam int unsigned IN_CODE_ZERO  = 0;
    localparam int unsigned IN_CODE_ONE   = 1;
    localparam int unsigned IN_CODE_BASE  = 2;
    // pad-output select codes
    localparam int unsigned OUT_CODE_ZERO = 0;
    localparam int unsigned OUT_CODE_ONE  = 1;
    localparam int unsigned OUT_CODE_HIZ  = 2;
    localparam int unsigned OUT_CODE_BASE = 3;
endpackage

// File: rtl/pad_route_regs.sv
// Module: pad_route_regs
// Register file holding the lock bit and all route selects.
// Assumes word-aligned byte offsets. Word 0 is the lock, then the input
// selects, then the output selects. Reads are combinational.
module pad_route_regs
    import pad_route_pkg::*;
#(
    parameter int unsigned N_PIN     = 8,
    parameter int unsigned N_PAD     = 4,
    parameter int unsigned IN_SEL_W  = 3,
    parameter int unsigned OUT_SEL_W = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    input  logic                              reg_we,
    output logic [REG_W-1:0]                  reg_rdata,
    output logic                              cfg_lock,
    output logic [N_PIN-1:0][IN_SEL_W-1:0]    in_sel,
    output logic [N_PAD-1:0][OUT_SEL_W-1:0]   out_sel
);
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned IN_BASE  = 1;
    localparam int unsigned OUT_BASE = IN_BASE + N_PIN;

    logic [WORD_W-1:0] word_idx;
    logic              lock_q;

    assign word_idx = reg_addr[ADDR_W-1:2];
    assign cfg_lock = lock_q;

    // lock bit: set by reset, cleared by writing one, never set again
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b1;
        else if (reg_we && word_idx == '0 && reg_wdata[0])
            lock_q <= 1'b0;
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_in_reg
        localparam logic [WORD_W-1:0] IDX = WORD_W'(IN_BASE + i);
        // input select storage, writable only while unlocked
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_sel[i] <= IN_SEL_W'(IN_CODE_ZERO);
            else if (lock_q && reg_we && word_idx == IDX)
                in_sel[i] <= reg_wdata[IN_SEL_W-1:0];
        end
    end

    for (genvar j = 0; j < N_PAD; j++) begin : g_out_reg
        localparam logic [WORD_W-1:0] IDX = WORD_W'(OUT_BASE + j);
        // output select storage, reset to high impedance
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_sel[j] <= OUT_SEL_W'(OUT_CODE_HIZ);
            else if (lock_q && reg_we && word_idx == IDX)
                out_sel[j] <= reg_wdata[OUT_SEL_W-1:0];
        end
    end

    // read-back multiplexer, zero for unused bits and unmapped words
    always_comb begin
        reg_rdata = '0;
        if (word_idx == '0)
            reg_rdata[0] = lock_q;
        for (int i = 0; i < N_PIN; i++)
            if (word_idx == WORD_W'(IN_BASE + i))
                reg_rdata[IN_SEL_W-1:0] = in_sel[i];
        for (int j = 0; j < N_PAD; j++)
            if (word_idx == WORD_W'(OUT_BASE + j))
                reg_rdata[OUT_SEL_W-1:0] = out_sel[j];
    end
endmodule

// File: rtl/pad_route_in_mux.sv
// Module: pad_route_in_mux
// Picks each peripheral input from a pad or a fixed level.
// Assumes codes that point past the last pad mean constant zero.
module pad_route_in_mux
    import pad_route_pkg::*;
#(
    parameter int unsigned N_PIN = 8,
    parameter int unsigned N_PAD = 4,
    parameter int unsigned SEL_W = 3
) (
    input  logic [N_PIN-1:0][SEL_W-1:0] sel,
    input  logic [N_PAD-1:0]            pad_in,
    output logic [N_PIN-1:0]            periph_in
);
    for (genvar i = 0; i < N_PIN; i++) begin : g_in
        logic bit_v;
        // decode one select: constant one, a pad, or zero by default
        always_comb begin
            bit_v = 1'b0;
            if (sel[i] == SEL_W'(IN_CODE_ONE))
                bit_v = 1'b1;
            for (int p = 0; p < N_PAD; p++)
                if (sel[i] == SEL_W'(IN_CODE_BASE + p))
                    bit_v = pad_in[p];
        end
        assign periph_in[i] = bit_v;
    end
endmodule

// File: rtl/pad_route_out_mux.sv
// Module: pad_route_out_mux
// Drives each pad's data and enable from a peripheral output or a fixed level.
// Assumes unknown codes float the pad. Data is forced low whenever enable is low.
module pad_route_out_mux
    import pad_route_pkg::*;
#(
    parameter int unsigned N_POUT = 8,
    parameter int unsigned N_PAD  = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [N_PAD-1:0][SEL_W-1:0] sel,
    input  logic [N_POUT-1:0]           periph_out,
    output logic [N_PAD-1:0]            pad_out,
    output logic [N_PAD-1:0]            pad_oe
);
    for (genvar j = 0; j < N_PAD; j++) begin : g_out
        logic oe_v;
        logic dat_v;
        // decode one select into an enable and data pair
        always_comb begin
            oe_v  = 1'b0;
            dat_v = 1'b0;
            if (sel[j] == SEL_W'(OUT_CODE_ZERO)) begin
                oe_v = 1'b1;
            end else if (sel[j] == SEL_W'(OUT_CODE_ONE)) begin
                oe_v  = 1'b1;
                dat_v = 1'b1;
            end
            for (int p = 0; p < N_POUT; p++)
                if (sel[j] == SEL_W'(OUT_CODE_BASE + p)) begin
                    oe_v  = 1'b1;
                    dat_v = periph_out[p];
                end
        end
        assign pad_oe[j]  = oe_v;
        assign pad_out[j] = dat_v;
    end
endmodule

// File: rtl/pad_route_mux.sv
// Module: pad_route_mux
// Top of the lockable pad multiplexer: register file plus both route muxes.
// Assumes a single clock domain. Pad inputs arrive already synchronised.
module pad_route_mux
    import pad_route_pkg::*;
#(
    parameter int unsigned N_PIN     = 8,
    parameter int unsigned N_POUT    = 8,
    parameter int unsigned N_PAD     = 4,
    parameter int unsigned IN_SEL_W  = 3,
    parameter int unsigned OUT_SEL_W = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output logic [N_PIN-1:0]  periph_to_core,
    input  logic [N_POUT-1:0] periph_from_core,
    input  logic [N_PAD-1:0]  pad_in,
    output logic [N_PAD-1:0]  pad_out,
    output logic [N_PAD-1:0]  pad_oe
);
    logic                            cfg_lock;
    logic [N_PIN-1:0][IN_SEL_W-1:0]  in_sel;
    logic [N_PAD-1:0][OUT_SEL_W-1:0] out_sel;

    pad_route_regs #(
        .N_PIN(N_PIN), .N_PAD(N_PAD), .IN_SEL_W(IN_SEL_W),
        .OUT_SEL_W(OUT_SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .cfg_lock(cfg_lock),
        .in_sel(in_sel), .out_sel(out_sel)
    );

    pad_route_in_mux #(.N_PIN(N_PIN), .N_PAD(N_PAD), .SEL_W(IN_SEL_W)) u_in_mux (
        .sel(in_sel), .pad_in(pad_in), .periph_in(periph_to_core)
    );

    pad_route_out_mux #(.N_POUT(N_POUT), .N_PAD(N_PAD), .SEL_W(OUT_SEL_W)) u_out_mux (
        .sel(out_sel), .periph_out(periph_from_core), .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: rtl/pad_route_chk.sv
// Module: pad_route_chk
// Assertion checker bound to pad_route_mux. It watches the lock, the selects
// and the pad and peripheral-input outputs.
module pad_route_chk #(
    parameter int unsigned N_PIN     = 8,
    parameter int unsigned N_POUT    = 8,
    parameter int unsigned N_PAD     = 4,
    parameter int unsigned IN_SEL_W  = 3,
    parameter int unsigned OUT_SEL_W = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [31:0]                     reg_wdata,
    input logic                            reg_we,
    input logic                            cfg_lock,
    input logic [N_PIN-1:0][IN_SEL_W-1:0]  in_sel,
    input logic [N_PAD-1:0][OUT_SEL_W-1:0] out_sel,
    input logic [N_PIN-1:0]                periph_to_core,
    input logic [N_PAD-1:0]                pad_out,
    input logic [N_PAD-1:0]                pad_oe
);
    localparam int unsigned WORD_W   = ADDR_W - 2;
    localparam int unsigned OUT_BASE = 1 + N_PIN;

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_lock |=> !cfg_lock);

    assert_lock_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[ADDR_W-1:2] == '0 && reg_wdata[0]) |=> !cfg_lock);

    assert_locked_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_lock |=> ($stable(in_sel) && $stable(out_sel)));

    assert_write_next_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && reg_we && reg_addr[ADDR_W-1:2] == WORD_W'(OUT_BASE))
        |=> out_sel[0] == $past(reg_wdata[OUT_SEL_W-1:0]));

    assert_oe_gates_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    for (genvar j = 0; j < N_PAD; j++) begin : g_pad_chk
        assert_hiz_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_sel[j] == OUT_SEL_W'(2) |-> !pad_oe[j]);
        assert_low_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_sel[j] == OUT_SEL_W'(0) |-> (pad_oe[j] && !pad_out[j]));
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_in_chk
        assert_one_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_sel[i] == IN_SEL_W'(1) |-> periph_to_core[i]);
    end
endmodule

bind pad_route_mux pad_route_chk #(
    .N_PIN(N_PIN), .N_POUT(N_POUT), .N_PAD(N_PAD),
    .IN_SEL_W(IN_SEL_W), .OUT_SEL_W(OUT_SEL_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_pad_route_mux.sv
// Bench for pad_route_mux: exhaustive select-code sweeps with arithmetic expectations.
module tb_pad_route_mux;
    localparam int N_PIN = 8, N_POUT = 8, N_PAD = 4;
    localparam logic [7:0] A_LOCK = 8'h00, A_IN0 = 8'h04, A_OUT0 = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic [31:0] reg_rdata;
    logic [7:0]  periph_to_core;
    logic [7:0]  periph_from_core;
    logic [3:0]  pad_in;
    logic [3:0]  pad_out;
    logic [3:0]  pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pad_route_mux dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic exp_in(int code, logic [3:0] pads);
        if (code == 1) return 1'b1;
        if (code >= 2 && code < 2 + N_PAD) return pads[code-2];
        return 1'b0;
    endfunction

    function automatic logic exp_oe(int code);
        return (code == 0 || code == 1 || (code >= 3 && code < 3 + N_POUT));
    endfunction

    function automatic logic exp_out(int code, logic [7:0] per);
        if (code == 1) return 1'b1;
        if (code >= 3 && code < 3 + N_POUT) return per[code-3];
        return 1'b0;
    endfunction

    // watchdog: a hung run is a failed check and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        pad_in = 4'hF; periph_from_core = 8'hFF;
        do_reset();

        // R1: reset state
        rd(A_LOCK, d); chk("R1 lock", d, 1);
        for (int i = 0; i < N_PIN; i++) begin rd(A_IN0 + 8'(4*i), d); chk("R1 in_sel", d, 0); end
        for (int j = 0; j < N_PAD; j++) begin rd(A_OUT0 + 8'(4*j), d); chk("R1 out_sel", d, 2); end
        chk("R1 pad_oe", {28'd0, pad_oe}, 0);
        chk("R1 pad_out", {28'd0, pad_out}, 0);
        chk("R1 periph_to_core", {24'd0, periph_to_core}, 0);

        // R13: old value during write cycle, new value after the edge
        @(negedge clk);
        reg_addr = A_IN0; reg_wdata = 32'd5; reg_we = 1'b1;
        #2 chk("R13 before edge", reg_rdata, 0);
        @(posedge clk); #1 chk("R13 after edge", reg_rdata, 5);
        @(negedge clk); reg_we = 1'b0;

        // R2: field widths and unused bits
        for (int i = 0; i < N_PIN; i++) begin
            wr(A_IN0 + 8'(4*i), 32'hFFFF_FFFF); rd(A_IN0 + 8'(4*i), d); chk("R2 in width", d, 7);
        end
        for (int j = 0; j < N_PAD; j++) begin
            wr(A_OUT0 + 8'(4*j), 32'hFFFF_FFFF); rd(A_OUT0 + 8'(4*j), d); chk("R2 out width", d, 15);
        end
        wr(A_LOCK, 32'hFFFF_FFFE); rd(A_LOCK, d); chk("R2 R11 lock word", d, 1);

        // R3: unmapped offsets read zero and writes there change nothing
        wr(8'h34, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        for (int a = 8'h34; a <= 8'hFC; a += 4) begin rd(8'(a), d); chk("R3 unmapped read", d, 0); end
        for (int i = 0; i < N_PIN; i++) begin rd(A_IN0 + 8'(4*i), d); chk("R3 in kept", d, 7); end
        for (int j = 0; j < N_PAD; j++) begin rd(A_OUT0 + 8'(4*j), d); chk("R3 out kept", d, 15); end
        rd(A_LOCK, d); chk("R3 lock kept", d, 1);

        // R4 R5 R6: every input code against every pad pattern
        for (int i = 0; i < N_PIN; i++)
            for (int code = 0; code < 8; code++) begin
                wr(A_IN0 + 8'(4*i), 32'(code));
                for (int p = 0; p < 16; p++) begin
                    pad_in = 4'(p);
                    #1 chk(code < 2 ? "R4 input const" : (code < 6 ? "R5 input pad" : "R6 input range"),
                           {31'd0, periph_to_core[i]}, {31'd0, exp_in(code, 4'(p))});
                end
            end

        // R7 R8 R9 R10: every output code against several peripheral patterns
        for (int j = 0; j < N_PAD; j++)
            for (int code = 0; code < 16; code++) begin
                wr(A_OUT0 + 8'(4*j), 32'(code));
                for (int k = 0; k < 10; k++) begin
                    periph_from_core = (k < 8) ? 8'(1 << k) : ((k == 8) ? 8'h00 : 8'hFF);
                    #1;
                    chk(code < 2 ? "R7 pad oe" : (code == 2 ? "R8 pad oe" : (code < 11 ? "R9 pad oe" : "R10 pad oe")),
                        {31'd0, pad_oe[j]}, {31'd0, exp_oe(code)});
                    chk(code < 2 ? "R7 pad data" : (code == 2 ? "R8 pad data" : (code < 11 ? "R9 pad data" : "R10 pad data")),
                        {31'd0, pad_out[j]}, {31'd0, exp_out(code, periph_from_core)});
                end
            end

        // R11 R12: program routes, lock, try to change them
        for (int i = 0; i < N_PIN; i++) wr(A_IN0 + 8'(4*i), 32'(2 + (i % N_PAD)));
        for (int j = 0; j < N_PAD; j++) wr(A_OUT0 + 8'(4*j), 32'(3 + j));
        wr(A_LOCK, 32'd0); rd(A_LOCK, d); chk("R11 write zero ignored", d, 1);
        wr(A_LOCK, 32'd1); rd(A_LOCK, d); chk("R11 lock cleared", d, 0);
        wr(A_LOCK, 32'd1); rd(A_LOCK, d); chk("R11 lock not set again", d, 0);
        wr(A_IN0, 32'd1);  rd(A_IN0, d);  chk("R12 in_sel frozen", d, 2);
        pad_in = 4'b0000;
        #1 chk("R12 input route frozen", {31'd0, periph_to_core[0]}, 0);
        wr(A_OUT0, 32'd2); rd(A_OUT0, d); chk("R12 out_sel frozen", d, 3);
        periph_from_core = 8'h01;
        #1 chk("R12 pad oe frozen", {31'd0, pad_oe[0]}, 1);
        chk("R12 pad data frozen", {31'd0, pad_out[0]}, 1);

        // R1: only reset restores the lock and defaults
        do_reset();
        rd(A_LOCK, d); chk("R1 lock after re-reset", d, 1);
        rd(A_OUT0, d); chk("R1 out_sel after re-reset", d, 2);
        chk("R1 pad_oe after re-reset", {28'd0, pad_oe}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule